// File: doc/BRIEF.md
# I2C Digital-Potentiometer Command Slave

This block is the serial control front end of a 256-step digital potentiometer. It watches an I2C-compatible bus through a fast system clock and answers one of four 7-bit device addresses, chosen by two strap pins. It decodes an instruction byte made of a three-bit command and a five-bit pointer. From that it updates the wiper code, asks an external nonvolatile sequencer to write a byte, pulses store, restore and no-operation strobes, or sets and clears a software write-protect flag.

Reads return the wiper code, the write-protect flag, the nonvolatile byte supplied by the sequencer, or one of two factory tolerance bytes. The command and pointer survive a repeated start, so a read may follow the instruction directly or skip it entirely when the wanted register was the last one addressed. One instruction may be followed by any number of wiper data bytes, and each byte updates the wiper as it arrives. A master acknowledge during a read of the tolerance integer byte advances the pointer to the fraction byte.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The straps are captured during reset and select the address as {strap_a1, strap_a0}: 00 gives 0x18, 10 gives 0x1A, 01 gives 0x4C, 11 gives 0x4E. A matching address byte is acknowledged (SDA low on the ninth clock).
- R2: An address byte that does not match gets no acknowledge, and the bytes that follow it up to the next start have no effect on the wiper or on the protect flag.
- R3: With command 000, every data byte after the instruction byte loads wiper_o, until a stop or a start.
- R4: After reset, wiper_o is 0x80, wp_o is 0 and sda_oe is 0.
- R5: With command 010, bit 0 of each data byte sets (1) or clears (0) wp_o. While wp_o is 1, wiper and nonvolatile data bytes are still acknowledged but discarded. A read with command 010 returns {7'b0, wp_o}.
- R6: With command 001 and a pointer below 11110, each data byte pulses nv_wr_req for one cycle with nv_wr_data holding the byte. A read with command 001 returns nv_rd_data.
- R7: An instruction byte alone pulses nop_stb for command 100, restore_stb for command 101 and store_stb for command 110, each for one cycle. At most one strobe or write request is high in any cycle.
- R8: The command and pointer are kept across repeated start and across separate transactions. A read with no instruction byte returns the register that was last addressed.
- R9: With command 001, pointer 11110 reads tol_int and pointer 11111 reads tol_frac. A master ACK after the 11110 byte moves the pointer to 11111.
- R10: Read bits are launched after SCL falls and only start to be driven while SCL is low. After the master's NACK the slave leaves SDA released.
- R11: The instruction byte is laid out with the command in bits 7:5 and the pointer in bits 4:0. Pointer bits do not change a wiper write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_a1 | input | 1 | Address strap, upper |
| strap_a0 | input | 1 | Address strap, lower |
| nv_rd_data | input | 8 | Nonvolatile byte offered by the sequencer for readback |
| tol_int | input | 8 | Tolerance sign and integer byte |
| tol_frac | input | 8 | Tolerance fraction byte |
| wiper_o | output | 8 | Wiper code |
| wp_o | output | 1 | Software write protect |
| nv_wr_req | output | 1 | One-cycle nonvolatile write request |
| nv_wr_data | output | 8 | Data for the nonvolatile write |
| store_stb | output | 1 | One-cycle store strobe |
| restore_stb | output | 1 | One-cycle restore strobe |
| nop_stb | output | 1 | One-cycle no-operation strobe |

## Verification
The hardest state to reach is a read that depends on earlier traffic. The pointer advance only happens on a master ACK partway through a two-byte read, and a later read that has no instruction byte must see the advanced pointer. The bench drives a bit-level master that issues repeated starts and per-byte ACK or NACK. It runs a consecutive tolerance read and then a bare read with no instruction byte. It also reads back after write protect has silently dropped wiper bytes. Random transactions then mix protect toggles, wiper bursts, foreign-address traffic and pointer reads against a bench model of the registers.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
// Shared constants for the potentiometer command slave: command codes,
// link states, tolerance pointer values and the strap address decode.
package dpot_pkg;
    localparam int BYTE_W = 8;
    localparam int CMD_W  = 3;
    localparam int PTR_W  = BYTE_W - CMD_W;

    localparam logic [CMD_W-1:0] CMD_WIPER   = 3'b000;
    localparam logic [CMD_W-1:0] CMD_NVM     = 3'b001;
    localparam logic [CMD_W-1:0] CMD_PROT    = 3'b010;
    localparam logic [CMD_W-1:0] CMD_NOP     = 3'b100;
    localparam logic [CMD_W-1:0] CMD_RESTORE = 3'b101;
    localparam logic [CMD_W-1:0] CMD_STORE   = 3'b110;

    localparam logic [PTR_W-1:0] TOL_INT_PTR  = 5'b11110;
    localparam logic [PTR_W-1:0] TOL_FRAC_PTR = 5'b11111;

    typedef enum logic [2:0] {
        LK_IDLE, LK_ADDR, LK_ADDR_ACK, LK_WR, LK_WR_ACK, LK_RD, LK_RD_ACK
    } link_state_e;

    // Strap pair to 7-bit device address.
    function automatic logic [6:0] strap_to_addr(input logic a1, input logic a0);
        return a0 ? {5'b10011, a1, 1'b0} : {5'b00110, a1, 1'b0};
    endfunction
endpackage

// File: rtl/i2c_line_sampler.sv
`timescale 1ns/1ps
// Synchronises SCL/SDA into clk and flags edges, start and stop.
// Assumes clk is at least several times faster than SCL.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sync, sda_sync;
    logic         scl_d, sda_d, scl_s;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[TOP-1:0], scl_i};
            sda_sync <= {sda_sync[TOP-1:0], sda_i};
            scl_d    <= scl_sync[TOP];
            sda_d    <= sda_sync[TOP];
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_s     = scl_sync[TOP];
        sda_s     = sda_sync[TOP];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_byte_link.sv
`timescale 1ns/1ps
// Byte-level I2C slave: address match, ACK on ninth clock, receive bytes,
// transmit bytes on SCL falling edges, report master ACK for the next byte.
// Assumes no clock stretching and 7-bit addressing only.
module i2c_byte_link
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic              rx_first,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_next
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    link_state_e       state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_q, first_pending, acked;

    // Bus protocol state machine.
    always_ff @(posedge clk) begin
        rx_valid <= 1'b0;
        tx_next  <= 1'b0;
        if (!rst_n) begin
            state         <= LK_IDLE;
            bit_cnt       <= '0;
            shreg         <= '0;
            rw_q          <= 1'b0;
            first_pending <= 1'b0;
            acked         <= 1'b0;
            sda_oe        <= 1'b0;
            rx_first      <= 1'b0;
            rx_data       <= '0;
        end else if (start_det) begin
            state   <= LK_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= LK_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                LK_ADDR, LK_WR: begin
                    if (scl_rise && bit_cnt < BITS) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == BITS) begin
                        if (state == LK_ADDR) begin
                            if (shreg[BYTE_W-1:1] == dev_addr) begin
                                rw_q          <= shreg[0];
                                first_pending <= 1'b1;
                                sda_oe        <= 1'b1;
                                state         <= LK_ADDR_ACK;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end else begin
                            rx_valid      <= 1'b1;
                            rx_first      <= first_pending;
                            rx_data       <= shreg;
                            first_pending <= 1'b0;
                            sda_oe        <= 1'b1;
                            state         <= LK_WR_ACK;
                        end
                    end
                end
                LK_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[BYTE_W-1];
                            state  <= LK_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= LK_WR;
                        end
                    end
                end
                LK_WR_ACK: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= LK_WR;
                    end
                end
                LK_RD: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == BITS) begin
                            sda_oe <= 1'b0;
                            state  <= LK_RD_ACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                LK_RD_ACK: begin
                    if (scl_rise) begin
                        acked   <= ~sda_s;
                        tx_next <= ~sda_s;
                    end else if (scl_fall) begin
                        if (acked) begin
                            bit_cnt <= '0;
                            shreg   <= tx_byte;
                            sda_oe  <= ~tx_byte[BYTE_W-1];
                            state   <= LK_RD;
                        end else begin
                            state <= LK_IDLE;
                        end
                    end
                end
                default: state <= LK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dpot_cmd_regs.sv
`timescale 1ns/1ps
// Command decoder and register set: latches command/pointer from the
// instruction byte, applies data bytes, builds the readback byte.
// Assumes rx_first marks the first byte after a write address.
module dpot_cmd_regs
    import dpot_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WIPER_RESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_next,
    input  logic [BYTE_W-1:0] nv_rd_data,
    input  logic [BYTE_W-1:0] tol_int,
    input  logic [BYTE_W-1:0] tol_frac,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] wiper_o,
    output logic              wp_o,
    output logic              nv_wr_req,
    output logic [BYTE_W-1:0] nv_wr_data,
    output logic              store_stb,
    output logic              restore_stb,
    output logic              nop_stb
);
    logic [CMD_W-1:0] cmd_q;
    logic [PTR_W-1:0] ptr_q;
    logic             ptr_is_tol;

    assign ptr_is_tol = (ptr_q[PTR_W-1:1] == TOL_INT_PTR[PTR_W-1:1]);

    // Instruction latch, data byte actions, pointer advance.
    always_ff @(posedge clk) begin
        store_stb   <= 1'b0;
        restore_stb <= 1'b0;
        nop_stb     <= 1'b0;
        nv_wr_req   <= 1'b0;
        if (!rst_n) begin
            cmd_q      <= CMD_WIPER;
            ptr_q      <= '0;
            wiper_o    <= WIPER_RESET;
            wp_o       <= 1'b0;
            nv_wr_data <= '0;
        end else if (rx_valid && rx_first) begin
            cmd_q       <= rx_data[BYTE_W-1:PTR_W];
            ptr_q       <= rx_data[PTR_W-1:0];
            nop_stb     <= (rx_data[BYTE_W-1:PTR_W] == CMD_NOP);
            restore_stb <= (rx_data[BYTE_W-1:PTR_W] == CMD_RESTORE);
            store_stb   <= (rx_data[BYTE_W-1:PTR_W] == CMD_STORE);
        end else if (rx_valid) begin
            unique case (cmd_q)
                CMD_WIPER: if (!wp_o) wiper_o <= rx_data;
                CMD_NVM: begin
                    if (!wp_o && !ptr_is_tol) begin
                        nv_wr_req  <= 1'b1;
                        nv_wr_data <= rx_data;
                    end
                end
                CMD_PROT: wp_o <= rx_data[0];
                default: ;
            endcase
        end else if (tx_next && cmd_q == CMD_NVM && ptr_q == TOL_INT_PTR) begin
            ptr_q <= TOL_FRAC_PTR;
        end
    end

    // Readback selection from command and pointer.
    always_comb begin
        unique case (cmd_q)
            CMD_NVM: begin
                if (ptr_q == TOL_INT_PTR)       tx_byte = tol_int;
                else if (ptr_q == TOL_FRAC_PTR) tx_byte = tol_frac;
                else                            tx_byte = nv_rd_data;
            end
            CMD_PROT: tx_byte = {{(BYTE_W-1){1'b0}}, wp_o};
            default:  tx_byte = wiper_o;
        endcase
    end
endmodule

// File: rtl/dpot_i2c_slave.sv
`timescale 1ns/1ps
// Top of the potentiometer command slave: captures the straps at reset,
// joins the bus sampler, byte link and command registers.
// Assumes SDA is open drain: sda_oe pulls low, release means high.
module dpot_i2c_slave
    import dpot_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] WIPER_RESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              strap_a1,
    input  logic              strap_a0,
    input  logic [BYTE_W-1:0] nv_rd_data,
    input  logic [BYTE_W-1:0] tol_int,
    input  logic [BYTE_W-1:0] tol_frac,
    output logic [BYTE_W-1:0] wiper_o,
    output logic              wp_o,
    output logic              nv_wr_req,
    output logic [BYTE_W-1:0] nv_wr_data,
    output logic              store_stb,
    output logic              restore_stb,
    output logic              nop_stb
);
    logic [6:0]        dev_addr_q;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              rx_valid, rx_first, tx_next;
    logic [BYTE_W-1:0] rx_data, tx_byte;

    // Strap capture while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_addr_q <= strap_to_addr(strap_a1, strap_a0);
    end

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_link i_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr_q), .tx_byte(tx_byte), .sda_oe(sda_oe),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_data(rx_data),
        .tx_next(tx_next)
    );

    dpot_cmd_regs #(.WIPER_RESET(WIPER_RESET)) i_regs (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_data(rx_data), .tx_next(tx_next), .nv_rd_data(nv_rd_data),
        .tol_int(tol_int), .tol_frac(tol_frac), .tx_byte(tx_byte),
        .wiper_o(wiper_o), .wp_o(wp_o), .nv_wr_req(nv_wr_req),
        .nv_wr_data(nv_wr_data), .store_stb(store_stb),
        .restore_stb(restore_stb), .nop_stb(nop_stb)
    );
endmodule

// File: rtl/dpot_i2c_slave_chk.sv
`timescale 1ns/1ps
// Port-level temporal checks for dpot_i2c_slave, attached by bind.
module dpot_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [7:0] wiper_o,
    input logic       wp_o,
    input logic       nv_wr_req,
    input logic       store_stb,
    input logic       restore_stb,
    input logic       nop_stb
);
    // R5
    wiper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wp_o) |-> $stable(wiper_o));

    // R5
    nv_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_req |-> !wp_o);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_stb, restore_stb, nop_stb, nv_wr_req}));

    // R7
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |=> !store_stb);

    // R7
    restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_stb |=> !restore_stb);

    // R10
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .wiper_o(wiper_o), .wp_o(wp_o), .nv_wr_req(nv_wr_req),
    .store_stb(store_stb), .restore_stb(restore_stb), .nop_stb(nop_stb)
);

// File: tb/test_dpot_i2c_slave.sv
`timescale 1ns/1ps
module test_dpot_i2c_slave;
    localparam int Q = 8;
    localparam logic [7:0] NV_RD = 8'h5A;
    localparam logic [7:0] TOL_I = 8'h9C;
    localparam logic [7:0] TOL_F = 8'h0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic strap_a1 = 1'b0, strap_a0 = 1'b0;
    logic sda_oe, wp_o, nv_wr_req, store_stb, restore_stb, nop_stb;
    logic [7:0] wiper_o, nv_wr_data;
    wire  sda_line = sda_m & ~sda_oe;

    int n_checks = 0, n_err = 0;
    int nv_cnt = 0, store_cnt = 0, restore_cnt = 0, nop_cnt = 0;
    logic [7:0] nv_last = 8'h00;

    always #10 clk = ~clk;

    dpot_i2c_slave i_dpot_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_a1(strap_a1), .strap_a0(strap_a0),
        .nv_rd_data(NV_RD), .tol_int(TOL_I), .tol_frac(TOL_F),
        .wiper_o(wiper_o), .wp_o(wp_o), .nv_wr_req(nv_wr_req),
        .nv_wr_data(nv_wr_data), .store_stb(store_stb),
        .restore_stb(restore_stb), .nop_stb(nop_stb)
    );

    // Port monitor for one-cycle outputs.
    always @(posedge clk) begin
        if (rst_n) begin
            if (nv_wr_req) begin nv_cnt++; nv_last = nv_wr_data; end
            if (store_stb) store_cnt++;
            if (restore_stb) restore_cnt++;
            if (nop_stb) nop_cnt++;
        end
    end

    // Address table from the strap requirement.
    function automatic logic [6:0] addr_of(input logic [1:0] s);
        case (s)
            2'b00: return 7'h18;
            2'b10: return 7'h1A;
            2'b01: return 7'h4C;
            default: return 7'h4E;
        endcase
    endfunction

    logic [7:0] m_wiper;
    logic       m_wp;
    logic [2:0] m_cmd;
    logic [4:0] m_ptr;

    function automatic logic [7:0] exp_rd();
        case (m_cmd)
            3'b001: return (m_ptr == 5'd30) ? TOL_I : (m_ptr == 5'd31) ? TOL_F : NV_RD;
            3'b010: return {7'b0, m_wp};
            default: return m_wiper;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qwait(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait(); endtask
    task automatic bus_stop(); sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait(); endtask
    task automatic send_bit(input logic b); sda_m = b; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait(); endtask
    task automatic recv_bit(output logic r); sda_m = 1; qwait(); scl_m = 1; qwait(); r = sda_line; qwait(); scl_m = 0; qwait(); endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(~mack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] instr,
                            input logic [7:0] data, input int ndata, output logic ok);
        logic k;
        bus_start();
        wr_byte({a, 1'b0}, k); ok = k;
        wr_byte(instr, k); ok &= k;
        for (int i = 0; i < ndata; i++) begin wr_byte(data, k); ok &= k; end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic set_ptr, input logic [7:0] instr,
                           input int nbytes, output logic [7:0] d0, output logic [7:0] d1);
        logic k;
        d1 = 8'h00;
        bus_start();
        if (set_ptr) begin
            wr_byte({a, 1'b0}, k);
            wr_byte(instr, k);
            bus_start();
        end
        wr_byte({a, 1'b1}, k);
        chk("R1 read address ack", k, 1);
        rd_byte(nbytes > 1, d0);
        if (nbytes > 1) rd_byte(1'b0, d1);
        chk("R10 SDA released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic do_reset();
        rst_n = 0; repeat (4) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
        m_wiper = 8'h80; m_wp = 0; m_cmd = 3'b000; m_ptr = 5'd0;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic ok, k;
        logic [7:0] d0, d1, v;
        logic [6:0] dev;
        int op, c0;
        void'($urandom(32'd4242));

        // R1 R2 R4: every strap setting.
        for (int s = 0; s < 4; s++) begin
            {strap_a1, strap_a0} = 2'(s);
            do_reset();
            chk("R4 reset wiper", wiper_o, 8'h80);
            chk("R4 reset wp", wp_o, 0);
            chk("R4 reset sda_oe", sda_oe, 0);
            v = 8'(8'h11 * s + 3);
            do_write(addr_of(2'(s)), 8'h00, v, 1, ok);
            chk("R1 own address acked", ok, 1);
            chk("R1 wiper via own address", wiper_o, v);
            do_write(addr_of(2'(s + 1)), 8'h00, 8'hEE, 1, ok);
            chk("R2 foreign address not acked", ok, 0);
            chk("R2 foreign write ignored", wiper_o, v);
            do_write(addr_of(2'(s + 2)), 8'h40, 8'h01, 1, ok);
            chk("R2 foreign protect ignored", wp_o, 0);
        end
        strap_a1 = 0; strap_a0 = 0;
        do_reset();
        dev = 7'h18;

        // R3: repeated data bytes under one instruction.
        bus_start();
        wr_byte({dev, 1'b0}, k); wr_byte(8'h00, k);
        wr_byte(8'h21, k); chk("R3 burst byte 1", wiper_o, 8'h21);
        wr_byte(8'hFF, k); chk("R3 burst byte 2", wiper_o, 8'hFF);
        wr_byte(8'h00, k); chk("R3 burst byte 3", wiper_o, 8'h00);
        bus_stop();
        m_wiper = 8'h00;

        // R11: pointer bits ignored for a wiper write.
        do_write(dev, 8'h1F, 8'h64, 1, ok);
        chk("R11 wiper write with pointer bits set", wiper_o, 8'h64);
        m_wiper = 8'h64;

        // R7: strobes from a lone instruction byte.
        do_write(dev, 8'hC0, 8'h00, 0, ok);
        chk("R7 store strobe", store_cnt, 1);
        do_write(dev, 8'hA0, 8'h00, 0, ok);
        chk("R7 restore strobe", restore_cnt, 1);
        do_write(dev, 8'h80, 8'h00, 0, ok);
        chk("R7 nop strobe", nop_cnt, 1);
        chk("R7 store not repeated", store_cnt, 1);

        // R6: nonvolatile write and readback.
        do_write(dev, 8'h20, 8'h3C, 1, ok);
        chk("R6 nv request count", nv_cnt, 1);
        chk("R6 nv data", nv_last, 8'h3C);
        do_read(dev, 1, 8'h20, 1, d0, d1);
        chk("R6 nv readback", d0, NV_RD);

        // R9 R8: consecutive tolerance read, then bare read.
        do_read(dev, 1, 8'h3E, 2, d0, d1);
        chk("R9 tolerance integer", d0, TOL_I);
        chk("R9 tolerance fraction after ACK", d1, TOL_F);
        do_read(dev, 0, 8'h00, 1, d0, d1);
        chk("R8 pointer advanced and kept", d0, TOL_F);
        do_read(dev, 1, 8'h3F, 1, d0, d1);
        chk("R9 fraction read alone", d0, TOL_F);

        // R8: last written register read without dummy bytes.
        do_write(dev, 8'h00, 8'h77, 1, ok);
        do_read(dev, 0, 8'h00, 1, d0, d1);
        chk("R8 read wiper without instruction", d0, 8'h77);
        m_wiper = 8'h77;

        // R5: write protect.
        do_write(dev, 8'h40, 8'h01, 1, ok);
        chk("R5 protect set", wp_o, 1);
        do_read(dev, 1, 8'h40, 1, d0, d1);
        chk("R5 protect readback", d0, 8'h01);
        do_write(dev, 8'h00, 8'hAA, 2, ok);
        chk("R5 protected write still acked", ok, 1);
        chk("R5 protected wiper kept", wiper_o, 8'h77);
        c0 = nv_cnt;
        do_write(dev, 8'h20, 8'h99, 1, ok);
        chk("R5 protected nv write dropped", nv_cnt, c0);
        do_write(dev, 8'h40, 8'hFE, 1, ok);
        chk("R5 protect cleared by LSB 0", wp_o, 0);
        do_write(dev, 8'h00, 8'h42, 1, ok);
        chk("R5 wiper writable again", wiper_o, 8'h42);
        m_wiper = 8'h42; m_wp = 0; m_cmd = 3'b000; m_ptr = 5'd0;

        // Random mix against the model.
        for (int it = 0; it < 16; it++) begin
            op = $urandom_range(0, 3);
            v = 8'($urandom_range(0, 255));
            case (op)
                0: begin
                    do_write(dev, 8'h00, v, 1 + $urandom_range(0, 1), ok);
                    if (!m_wp) m_wiper = v;
                    m_cmd = 3'b000; m_ptr = 5'd0;
                    chk("R3 random wiper write", wiper_o, m_wiper);
                    chk("R1 random ack", ok, 1);
                end
                1: begin
                    do_write(dev, 8'h40, v, 1, ok);
                    m_wp = v[0]; m_cmd = 3'b010; m_ptr = 5'd0;
                    chk("R5 random protect", wp_o, m_wp);
                end
                2: begin
                    case ($urandom_range(0, 3))
                        0: v = 8'h00;
                        1: v = 8'h40;
                        2: v = 8'h3E;
                        default: v = 8'h3F;
                    endcase
                    m_cmd = v[7:5]; m_ptr = v[4:0];
                    do_read(dev, 1, v, 1, d0, d1);
                    chk("R8 random pointer read", d0, exp_rd());
                end
                default: begin
                    do_write(7'h1A, 8'h00, v, 1, ok);
                    chk("R2 random foreign nack", ok, 0);
                    chk("R2 random foreign ignored", wiper_o, m_wiper);
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule